// File: doc/BRIEF.md
# Hardware Trap Priority Controller

This block gathers the run-time exception requests of a small microcontroller core and decides which of them the CPU enters next. Each hardware source (three reset sources, three class A faults, five class B faults) records its occurrence in a trap flag register. A pending request is entered only when its priority class is strictly above the class of the trap being serviced. On entry the block raises a one-cycle take pulse and gives the trap number together with the entry vector, which is always four times the trap number.

The block keeps a record of the active trap classes. A return strobe from the CPU ends the innermost service and restores the class that was active before it. While any hardware trap service is active, ordinary interrupts and peripheral transfer requests are held off through a blocking output. A software trap instruction may enter any trap number from 0x00 to 0x7F. It runs at the current priority and never changes the active class.

Top module: `trap_prio_ctrl`

## Requirements
- R1: After reset, take_o, prio_o, irq_block_o and every bit of flags_o are 0.
- R2: A request on any reset source enters trap number 0x00 with vector 0x000000 at priority 3.
- R3: Class A requests enter at priority 2 with these numbers and vectors: NMI (cls_a_req bit 0) 0x02/0x000008, stack overflow (bit 1) 0x04/0x000010, stack underflow (bit 2) 0x06/0x000018. No hardware entry ever uses a number from 0x0B to 0x0F.
- R4: Class B requests on any of cls_b_req bits 0..4, alone or together, cause a single entry with number 0x0A, vector 0x000028, priority 1.
- R5: A request sets its own flag. flags_o bits 2:0 hold the reset sources, bits 5:3 hold class A bits 0..2, and bits 10:6 hold class B bits 0..4. The flag rises one cycle after the request is sampled.
- R6: A flag is cleared only by a write with flag_clr_we high and a 0 in that bit of flag_clr_data. A 1 in the data leaves the flag as it is, and data is ignored while flag_clr_we is low.
- R7: A new request from a source whose flag is still set causes no entry.
- R8: If requests are pending together, they are entered in a fixed order: reset, then NMI, then stack overflow, then stack underflow, then class B.
- R9: A pending hardware trap is entered only when its class is strictly above the active class. Otherwise it stays pending until returns lower the active class.
- R10: irq_block_o is high while any hardware trap is active. A trap_ret pulse ends the innermost service, and prio_o falls back to the previously active class, or to 0 when none is left.
- R11: A software trap enters sw_trap_num with vector sw_trap_num*4. prio_o, irq_block_o and flags_o do not change. When a hardware entry is due in the same cycle, the software trap waits and is entered one cycle later at the new current priority.
- R12: take_o is high for exactly one cycle per entry, two clock edges after the request is sampled. num_o and vec_o are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_src_req | input | 3 | Reset source requests: hardware, software, watchdog |
| cls_a_req | input | 3 | Class A requests: NMI, stack overflow, stack underflow |
| cls_b_req | input | 5 | Class B fault requests |
| sw_trap_req | input | 1 | Software trap strobe |
| sw_trap_num | input | 7 | Software trap number |
| trap_ret | input | 1 | Return-from-trap strobe |
| flag_clr_we | input | 1 | Flag write enable |
| flag_clr_data | input | 11 | Flag write data; a 0 clears the bit |
| take_o | output | 1 | One-cycle trap entry pulse |
| vec_o | output | 24 | Entry vector address |
| num_o | output | 7 | Entry trap number |
| prio_o | output | 2 | Active hardware trap class (0 when none) |
| irq_block_o | output | 1 | Blocks ordinary interrupts |
| flags_o | output | 11 | Trap flag register |

## Verification
The bench uses the default parameters: three reset sources, three class A sources, five class B sources, 7-bit trap numbers and 24-bit vectors. With these sizes every priority class can be stacked to its full depth, and the complete fixed order can be driven from one request burst. It also covers the largest software number 0x7F, whose vector 0x1FC tests the top of the shifted vector range. A software trap is raised together with an NMI to check the one-cycle deferral and the priority it inherits.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_B    = 2'd1,
    LVL_A    = 2'd2,
    LVL_RST  = 2'd3
  } trap_lvl_e;

  localparam int unsigned LVL_CNT = 3;
endpackage

// File: rtl/trap_flags.sv
// One group of trap flags with a pending bit per source.
module trap_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         clr_we,
  input  logic [N-1:0] clr_keep,
  input  logic [N-1:0] consume,
  output logic [N-1:0] flags,
  output logic [N-1:0] pend
);
  logic [N-1:0] new_req, wipe, flags_d, pend_d;

  always_comb begin
    new_req = req & ~flags;              // set flag blocks re-entry (R7)
    wipe    = clr_we ? ~clr_keep : '0;   // zero bits clear (R6)
    flags_d = (flags & ~wipe) | new_req;
    pend_d  = (pend & ~consume) | new_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      pend  <= '0;
    end else begin
      flags <= flags_d;
      pend  <= pend_d;
    end
  end
endmodule

// File: rtl/trap_arbiter.sv
// Picks the next entry: highest class first, fixed order inside class A.
module trap_arbiter import trap_pkg::*; #(
  parameter int unsigned N_RST      = 3,
  parameter int unsigned N_A        = 3,
  parameter int unsigned N_B        = 5,
  parameter int unsigned NUM_W      = 7,
  parameter int unsigned RST_NUM    = 0,
  parameter int unsigned A_NUM_BASE = 2,
  parameter int unsigned A_NUM_STEP = 2,
  parameter int unsigned B_NUM      = 10
) (
  input  logic [N_RST-1:0] pend_rst,
  input  logic [N_A-1:0]   pend_a,
  input  logic [N_B-1:0]   pend_b,
  input  trap_lvl_e        cur_lvl,
  input  logic             sw_pend,
  input  logic [NUM_W-1:0] sw_num,
  output logic             hw_go,
  output logic             sw_go,
  output trap_lvl_e        hw_lvl,
  output logic [NUM_W-1:0] sel_num,
  output logic [N_RST-1:0] use_rst,
  output logic [N_A-1:0]   use_a,
  output logic [N_B-1:0]   use_b
);
  logic [N_A-1:0] a_one;
  int unsigned    a_idx;
  logic           a_found;

  always_comb begin
    a_one   = '0;
    a_idx   = 0;
    a_found = 1'b0;
    for (int i = 0; i < int'(N_A); i++) begin
      if (pend_a[i] && !a_found) begin
        a_found  = 1'b1;
        a_one[i] = 1'b1;
        a_idx    = i;
      end
    end
  end

  always_comb begin
    if (|pend_rst)    hw_lvl = LVL_RST;
    else if (|pend_a) hw_lvl = LVL_A;
    else if (|pend_b) hw_lvl = LVL_B;
    else              hw_lvl = LVL_NONE;

    hw_go   = (hw_lvl > cur_lvl);
    sw_go   = sw_pend && !hw_go;
    use_rst = '0;
    use_a   = '0;
    use_b   = '0;
    sel_num = sw_num;

    if (hw_go) begin
      unique case (hw_lvl)
        LVL_RST: begin
          use_rst = pend_rst;
          sel_num = NUM_W'(RST_NUM);
        end
        LVL_A: begin
          use_a   = a_one;
          sel_num = NUM_W'(A_NUM_BASE + A_NUM_STEP * a_idx);
        end
        LVL_B: begin
          use_b   = pend_b;
          sel_num = NUM_W'(B_NUM);
        end
        default: sel_num = sw_num;
      endcase
    end
  end
endmodule

// File: rtl/trap_lvl_stack.sv
// Active trap classes; one bit per class, top is the highest set bit.
module trap_lvl_stack import trap_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  trap_lvl_e push_lvl,
  input  logic      pop,
  output trap_lvl_e top_lvl,
  output logic      busy
);
  logic [LVL_CNT-1:0] act, act_d, top_mask, push_mask;

  always_comb begin
    top_mask = '0;
    top_lvl  = LVL_NONE;
    for (int i = 0; i < int'(LVL_CNT); i++) begin
      if (act[i]) begin
        top_mask    = '0;
        top_mask[i] = 1'b1;
        top_lvl     = trap_lvl_e'(2'(i + 1));
      end
    end
    push_mask = '0;
    if (push && push_lvl != LVL_NONE) push_mask[2'(push_lvl) - 2'd1] = 1'b1;
    act_d = (pop ? (act & ~top_mask) : act) | push_mask;
    busy  = |act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          act <= '0;
    else if (push || pop) act <= act_d;
  end
endmodule

// File: rtl/trap_prio_ctrl.sv
module trap_prio_ctrl import trap_pkg::*; #(
  parameter int unsigned N_RST      = 3,
  parameter int unsigned N_A        = 3,
  parameter int unsigned N_B        = 5,
  parameter int unsigned NUM_W      = 7,
  parameter int unsigned VEC_W      = 24,
  parameter int unsigned RST_NUM    = 0,
  parameter int unsigned A_NUM_BASE = 2,
  parameter int unsigned A_NUM_STEP = 2,
  parameter int unsigned B_NUM      = 10,
  parameter int unsigned FLAG_W     = N_RST + N_A + N_B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_RST-1:0]  rst_src_req,
  input  logic [N_A-1:0]    cls_a_req,
  input  logic [N_B-1:0]    cls_b_req,
  input  logic              sw_trap_req,
  input  logic [NUM_W-1:0]  sw_trap_num,
  input  logic              trap_ret,
  input  logic              flag_clr_we,
  input  logic [FLAG_W-1:0] flag_clr_data,
  output logic              take_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [NUM_W-1:0]  num_o,
  output logic [1:0]        prio_o,
  output logic              irq_block_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int unsigned A_LO = N_RST;
  localparam int unsigned B_LO = N_RST + N_A;
  localparam int unsigned PAD_W = VEC_W - NUM_W - 2;

  logic [N_RST-1:0] fl_rst, pd_rst, use_rst;
  logic [N_A-1:0]   fl_a, pd_a, use_a;
  logic [N_B-1:0]   fl_b, pd_b, use_b;
  trap_lvl_e        cur_lvl, hw_lvl;
  logic             hw_go, sw_go, busy;
  logic [NUM_W-1:0] sel_num;

  logic             take_q, take_d;
  logic [NUM_W-1:0] num_q;
  logic             sw_pend_q, sw_pend_d, sw_accept;
  logic [NUM_W-1:0] sw_num_q;

  trap_flags #(.N(N_RST)) u_fl_rst (
    .clk(clk), .rst_n(rst_n), .req(rst_src_req), .clr_we(flag_clr_we),
    .clr_keep(flag_clr_data[A_LO-1:0]), .consume(use_rst),
    .flags(fl_rst), .pend(pd_rst)
  );

  trap_flags #(.N(N_A)) u_fl_a (
    .clk(clk), .rst_n(rst_n), .req(cls_a_req), .clr_we(flag_clr_we),
    .clr_keep(flag_clr_data[B_LO-1:A_LO]), .consume(use_a),
    .flags(fl_a), .pend(pd_a)
  );

  trap_flags #(.N(N_B)) u_fl_b (
    .clk(clk), .rst_n(rst_n), .req(cls_b_req), .clr_we(flag_clr_we),
    .clr_keep(flag_clr_data[FLAG_W-1:B_LO]), .consume(use_b),
    .flags(fl_b), .pend(pd_b)
  );

  trap_arbiter #(
    .N_RST(N_RST), .N_A(N_A), .N_B(N_B), .NUM_W(NUM_W), .RST_NUM(RST_NUM),
    .A_NUM_BASE(A_NUM_BASE), .A_NUM_STEP(A_NUM_STEP), .B_NUM(B_NUM)
  ) u_arb (
    .pend_rst(pd_rst), .pend_a(pd_a), .pend_b(pd_b), .cur_lvl(cur_lvl),
    .sw_pend(sw_pend_q), .sw_num(sw_num_q), .hw_go(hw_go), .sw_go(sw_go),
    .hw_lvl(hw_lvl), .sel_num(sel_num), .use_rst(use_rst), .use_a(use_a),
    .use_b(use_b)
  );

  trap_lvl_stack u_stk (
    .clk(clk), .rst_n(rst_n), .push(hw_go), .push_lvl(hw_lvl),
    .pop(trap_ret), .top_lvl(cur_lvl), .busy(busy)
  );

  // next-state
  always_comb begin
    sw_accept = sw_trap_req && !sw_pend_q;
    sw_pend_d = (sw_pend_q && !sw_go) || sw_accept;
    take_d    = hw_go || sw_go;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q    <= 1'b0;
      sw_pend_q <= 1'b0;
    end else begin
      take_q    <= take_d;
      sw_pend_q <= sw_pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      num_q <= '0;
    else if (take_d) num_q <= sel_num;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sw_num_q <= '0;
    else if (sw_accept) sw_num_q <= sw_trap_num;
  end

  assign take_o      = take_q;
  assign num_o       = num_q;
  assign vec_o       = {{PAD_W{1'b0}}, num_q, 2'b00};
  assign prio_o      = 2'(cur_lvl);
  assign irq_block_o = busy;
  assign flags_o     = {fl_b, fl_a, fl_rst};
endmodule

// File: rtl/trap_prio_chk.sv
module trap_prio_chk #(
  parameter int unsigned NUM_W  = 7,
  parameter int unsigned FLAG_W = 11,
  parameter int unsigned B_NUM  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trap_ret,
  input logic              flag_clr_we,
  input logic              take_o,
  input logic [NUM_W-1:0]  num_o,
  input logic [1:0]        prio_o,
  input logic              irq_block_o,
  input logic [FLAG_W-1:0] flags_o
);
  p_block_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_block_o) |-> take_o);

  p_prio_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_o > $past(prio_o)) |-> take_o);

  p_prio_down_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_o < $past(prio_o)) |-> $past(trap_ret));

  p_rst_num_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && prio_o == 2'd3 && $past(prio_o) != 2'd3) |-> (num_o == '0));

  p_b_num_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && prio_o == 2'd1 && $past(prio_o) != 2'd1) |-> (num_o == NUM_W'(B_NUM)));

  p_no_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && prio_o > $past(prio_o)) |-> (num_o < NUM_W'(11) || num_o > NUM_W'(15)));

  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flag_clr_we) |-> ((flags_o & $past(flags_o)) == $past(flags_o)));
endmodule

bind trap_prio_ctrl trap_prio_chk #(
  .NUM_W(NUM_W), .FLAG_W(FLAG_W), .B_NUM(B_NUM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_ret(trap_ret), .flag_clr_we(flag_clr_we),
  .take_o(take_o), .num_o(num_o), .prio_o(prio_o), .irq_block_o(irq_block_o),
  .flags_o(flags_o)
);

// File: tb/tb_trap_prio_ctrl.sv
`timescale 1ns/1ps
module tb_trap_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  rst_src_req;
  logic [2:0]  cls_a_req;
  logic [4:0]  cls_b_req;
  logic        sw_trap_req;
  logic [6:0]  sw_trap_num;
  logic        trap_ret;
  logic        flag_clr_we;
  logic [10:0] flag_clr_data;
  logic        take_o;
  logic [23:0] vec_o;
  logic [6:0]  num_o;
  logic [1:0]  prio_o;
  logic        irq_block_o;
  logic [10:0] flags_o;

  int checks = 0;
  int errors = 0;
  logic [8:0] exp_q[$];   // {prio[1:0], num[6:0]}

  always #2.5 clk = ~clk;

  trap_prio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .rst_src_req(rst_src_req), .cls_a_req(cls_a_req),
    .cls_b_req(cls_b_req), .sw_trap_req(sw_trap_req), .sw_trap_num(sw_trap_num),
    .trap_ret(trap_ret), .flag_clr_we(flag_clr_we), .flag_clr_data(flag_clr_data),
    .take_o(take_o), .vec_o(vec_o), .num_o(num_o), .prio_o(prio_o),
    .irq_block_o(irq_block_o), .flags_o(flags_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_take(input logic [6:0] num, input logic [1:0] prio);
    exp_q.push_back({prio, num});
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_hw(input logic [2:0] r, input logic [2:0] a, input logic [4:0] b);
    rst_src_req = r; cls_a_req = a; cls_b_req = b;
    tick(1);
    rst_src_req = '0; cls_a_req = '0; cls_b_req = '0;
  endtask

  task automatic pulse_ret();
    trap_ret = 1'b1;
    tick(1);
    trap_ret = 1'b0;
  endtask

  task automatic write_flags(input logic we, input logic [10:0] d);
    flag_clr_we = we; flag_clr_data = d;
    tick(1);
    flag_clr_we = 1'b0; flag_clr_data = '0;
  endtask

  // scoreboard monitor: every entry pops one expected item (R2 R3 R4 R11 R12)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && take_o === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7 unexpected entry actual=%0h expected=none", num_o);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        if (num_o !== e[6:0] || prio_o !== e[8:7] || vec_o !== {15'd0, e[6:0], 2'b00}) begin
          errors++;
          $display("FAIL R12 entry actual=num %0h vec %0h prio %0d expected=num %0h vec %0h prio %0d",
                   num_o, vec_o, prio_o, e[6:0], {15'd0, e[6:0], 2'b00}, e[8:7]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cnt;
    rst_n = 1'b0;
    rst_src_req = '0; cls_a_req = '0; cls_b_req = '0;
    sw_trap_req = 1'b0; sw_trap_num = '0; trap_ret = 1'b0;
    flag_clr_we = 1'b0; flag_clr_data = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    chk("R1 take", take_o, 0);
    chk("R1 prio", prio_o, 0);
    chk("R1 block", irq_block_o, 0);
    chk("R1 flags", flags_o, 0);

    // R3 NMI entry, R5 flag position
    expect_take(7'h02, 2'd2);
    pulse_hw(3'b000, 3'b001, 5'b0);
    chk("R5 nmi flag", flags_o, 11'h008);
    tick(2);
    chk("R3 prio", prio_o, 2);
    chk("R10 block", irq_block_o, 1);

    // R9 equal class waits until return
    pulse_hw(3'b000, 3'b010, 5'b0);
    tick(3);
    chk("R9 still nmi", prio_o, 2);
    chk("R5 stkof flag", flags_o, 11'h018);
    expect_take(7'h04, 2'd2);
    pulse_ret();
    tick(3);
    chk("R9 stkof after ret", prio_o, 2);
    pulse_ret();
    tick(3);
    chk("R10 prio empty", prio_o, 0);
    chk("R10 unblock", irq_block_o, 0);

    // R6 full clear
    write_flags(1'b1, 11'h000);
    chk("R6 clear all", flags_o, 0);

    // R4 two class B faults -> one entry; R2 reset preempts
    expect_take(7'h0A, 2'd1);
    pulse_hw(3'b000, 3'b000, 5'b10001);
    tick(3);
    chk("R4 prio", prio_o, 1);
    chk("R5 b flags", flags_o, 11'h440);
    expect_take(7'h00, 2'd3);
    pulse_hw(3'b010, 3'b000, 5'b0);
    tick(3);
    chk("R2 prio", prio_o, 3);
    chk("R5 rst flag", flags_o, 11'h442);
    pulse_ret();
    tick(3);
    chk("R10 restore b", prio_o, 1);
    pulse_ret();
    tick(3);
    chk("R10 empty", prio_o, 0);

    // R6 selective clear and ignored data
    write_flags(1'b1, ~11'h040);
    chk("R6 keep ones", flags_o, 11'h402);
    write_flags(1'b0, 11'h000);
    chk("R6 we low", flags_o, 11'h402);
    write_flags(1'b1, 11'h000);

    // R7 no re-entry while flag set
    expect_take(7'h02, 2'd2);
    pulse_hw(3'b000, 3'b001, 5'b0);
    tick(3);
    pulse_ret();
    tick(3);
    pulse_hw(3'b000, 3'b001, 5'b0);
    tick(4);
    chk("R7 no entry prio", prio_o, 0);
    write_flags(1'b1, 11'h000);

    // R8 fixed order
    expect_take(7'h00, 2'd3);
    expect_take(7'h02, 2'd2);
    expect_take(7'h04, 2'd2);
    expect_take(7'h06, 2'd2);
    expect_take(7'h0A, 2'd1);
    pulse_hw(3'b001, 3'b111, 5'b00100);
    tick(3);
    chk("R8 first", prio_o, 3);
    for (int k = 0; k < 5; k++) begin
      pulse_ret();
      tick(3);
      chk("R8 order prio", prio_o, (k < 3) ? 2 : (k == 3) ? 1 : 0);
    end
    write_flags(1'b1, 11'h000);

    // R11 software trap, largest number
    expect_take(7'h7F, 2'd0);
    sw_trap_req = 1'b1; sw_trap_num = 7'h7F;
    tick(1);
    sw_trap_req = 1'b0;
    tick(3);
    chk("R11 prio", prio_o, 0);
    chk("R11 block", irq_block_o, 0);
    chk("R11 flags", flags_o, 0);

    // R11 software trap deferred behind NMI
    expect_take(7'h02, 2'd2);
    expect_take(7'h05, 2'd2);
    sw_trap_req = 1'b1; sw_trap_num = 7'h05; cls_a_req = 3'b001;
    tick(1);
    sw_trap_req = 1'b0; cls_a_req = '0;
    tick(4);
    chk("R11 defer prio", prio_o, 2);
    pulse_ret();
    tick(3);
    write_flags(1'b1, 11'h000);

    // R12 single-cycle pulse
    expect_take(7'h03, 2'd0);
    sw_trap_req = 1'b1; sw_trap_num = 7'h03;
    tick(1);
    sw_trap_req = 1'b0;
    cnt = 0;
    for (int k = 0; k < 4; k++) begin
      tick(1);
      if (take_o === 1'b1) cnt++;
    end
    chk("R12 pulse width", cnt, 1);
    chk("R12 vec held", vec_o, 24'h00000C);

    tick(2);
    chk("R12 queue empty", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule